// File: doc/BRIEF.md
# 8-bit Timer with Two Compare Channels

An eight-bit up-counter advances on a timer tick. A three-bit clock-select field picks the tick source: no tick at all, every system clock, or one of six rates divided down from a free-running internal divider. Two compare channels watch the counter. On a tick where the counter equals a channel's active compare value, that channel raises its match flag and inverts its output pin. The counter either runs the full range and rolls over at 0xFF, or it runs up to the active value of channel 0 and restarts from zero.

Software reaches the block through a simple register port. A write takes effect on the clock edge that samples it, and reads are combinational. Through this port software can load the counter, fill the two compare buffers, set the interrupt mask, clear flags and set the mode. A compare value written by software sits in a buffer until the counter restarts, so a period never ends on a half-updated value. While the timer is stopped, the buffer is copied straight through. The single interrupt line is asserted while any flag is set together with its mask bit.

Top module: `tmr8_dual_cmp`

## Requirements
- R1: After reset the counter, both compare buffers and active values, the mask, the flags and the control register read 0, `irq` is low and both `cmp_out` pins are low.
- R2: Control bits [2:0] select the tick. 0 gives no tick and 1 gives one tick per clock. Values 2 through 7 give one tick every 8, 32, 64, 128, 256 and 1024 clocks, taken from a divider that runs freely from reset. Any run of N×D consecutive clocks then carries exactly N ticks.
- R3: On each tick the counter steps up by one. While the select is 0 it holds its value.
- R4: Control bit 3 picks TOP: 0 means 0xFF and 1 means the active value of channel 0. A tick while the counter equals TOP sets it to 0x00.
- R5: Flag bit 0 (overflow) is set by a tick while the counter holds 0xFF.
- R6: Flag bit 1 (channel 0) and flag bit 2 (channel 1) are set by a tick while the counter equals that channel's active value. The same event inverts `cmp_out[0]` or `cmp_out[1]`.
- R7: A compare write goes into the channel's buffer, and a read returns the buffer. The buffer is copied to the active value on a tick that takes the counter from TOP to 0x00, and on every clock while the select is 0.
- R8: Writing the flag register clears each flag whose data bit is 1. A hardware set in the same cycle wins over the clear.
- R9: `irq` is high exactly when some flag bit and the mask bit at the same position are both 1.
- R10: A counter write wins over a tick in the same cycle. No compare match occurs on that cycle or on the next tick after it.
- R11: Register addresses: 0 counter, 1 channel 0 compare, 2 channel 1 compare, 3 mask (bits [2:0]), 4 flags (bits [2:0]), 5 control (bits [3:0]). Unused bits and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Combinational read data |
| irq | output | 1 | Interrupt request |
| cmp_out | output | 2 | Compare-toggled output pins, bit 0 for channel 0 |

## Verification
A write or a tick shows up in the counter, flags, pins and `irq` right after the rising edge that samples it. Reads and `irq` are combinational from those registers, so every result is due one edge after its stimulus. The bench drives inputs at the falling edge and samples the results at the next falling edge, one edge after the stimulus. Rate checks load the counter, open a window of exactly N×D edges and read the count at the end. Because the divider runs freely, the window length alone sets the expected count and the divider phase does not matter. Buffer timing is checked by its effect: the counter keeps counting past a newly written value until the next restart.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  localparam int NCH    = 2;
  localparam int FLG_W  = NCH + 1;
  localparam int ADDR_W = 3;
  localparam int CS_W   = 3;
  localparam int CTRL_W = CS_W + 1;

  localparam logic [ADDR_W-1:0] RA_CNT   = 3'd0;
  localparam logic [ADDR_W-1:0] RA_CMP0  = 3'd1;
  localparam logic [ADDR_W-1:0] RA_MASK  = 3'd3;
  localparam logic [ADDR_W-1:0] RA_FLAG  = 3'd4;
  localparam logic [ADDR_W-1:0] RA_CTRL  = 3'd5;

  // log2 of the divide ratio for each prescaled select value
  function automatic int cs_shift(input logic [CS_W-1:0] cs);
    case (cs)
      3'd2:    return 3;
      3'd3:    return 5;
      3'd4:    return 6;
      3'd5:    return 7;
      3'd6:    return 8;
      3'd7:    return 10;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale
  import tmr8_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CS_W-1:0] cs,
  output logic            tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [PRE_W-1:0] tap_mask;

  always_comb begin
    pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  always_comb begin
    for (int i = 0; i < PRE_W; i++) tap_mask[i] = (i < cs_shift(cs));
  end

  always_comb begin
    if (cs == '0)        tick = 1'b0;
    else if (cs == 3'd1) tick = 1'b1;
    else                 tick = ((pre_q & tap_mask) == tap_mask);
  end

endmodule

// File: rtl/tmr8_count.sv
module tmr8_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         wrap,
  output logic         ovf
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         adv;
  logic         at_top;

  always_comb begin
    adv    = tick && !ld;
    at_top = (cnt_q == top);
    wrap   = adv && at_top;
    ovf    = adv && (cnt_q == {W{1'b1}});
    if (ld)        cnt_d = ld_val;
    else if (adv)  cnt_d = at_top ? '0 : cnt_q + 1'b1;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/tmr8_cmp_chan.sv
module tmr8_cmp_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         buf_we,
  input  logic [W-1:0] buf_wd,
  input  logic         load,
  input  logic         tick,
  input  logic         blk,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] buf_val,
  output logic [W-1:0] act_val,
  output logic         hit,
  output logic         pin
);

  logic [W-1:0] buf_q, buf_d;
  logic [W-1:0] act_q, act_d;
  logic         pin_q, pin_d;

  always_comb begin
    hit   = tick && !blk && (cnt == act_q);
    buf_d = buf_we ? buf_wd : buf_q;
    act_d = load ? buf_q : act_q;
    pin_d = hit ? !pin_q : pin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
      pin_q <= 1'b0;
    end else begin
      buf_q <= buf_d;
      act_q <= act_d;
      pin_q <= pin_d;
    end
  end

  assign buf_val = buf_q;
  assign act_val = act_q;
  assign pin     = pin_q;

endmodule

// File: rtl/tmr8_dual_cmp.sv
module tmr8_dual_cmp
  import tmr8_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int PRE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WIDTH-1:0]  rd_data,
  output logic              irq,
  output logic [NCH-1:0]    cmp_out
);

  // reset release synchronizer
  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  logic [CS_W-1:0]  cs_q, cs_d;
  logic             topsel_q, topsel_d;
  logic [FLG_W-1:0] mask_q, mask_d;
  logic [FLG_W-1:0] flags_q, flags_d;
  logic             supp_q, supp_d;

  logic             tick;
  logic             cnt_wr;
  logic             wrap;
  logic             ovf;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] top_val;
  logic             load;
  logic             blk;
  logic [FLG_W-1:0] set_v, clr_v;

  logic [WIDTH-1:0] buf_val [NCH];
  logic [WIDTH-1:0] act_val [NCH];
  logic [NCH-1:0]   hit;

  assign cnt_wr  = wr_en && (wr_addr == RA_CNT);
  assign top_val = topsel_q ? act_val[0] : {WIDTH{1'b1}};
  assign load    = wrap || (cs_q == '0);
  assign blk     = supp_q || cnt_wr;

  tmr8_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .cs    (cs_q),
    .tick  (tick)
  );

  tmr8_count #(.W(WIDTH)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick   (tick),
    .ld     (cnt_wr),
    .ld_val (wr_data),
    .top    (top_val),
    .cnt    (cnt_q),
    .wrap   (wrap),
    .ovf    (ovf)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    tmr8_cmp_chan #(.W(WIDTH)) u_chan (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .buf_we  (wr_en && (wr_addr == ADDR_W'(int'(RA_CMP0) + g))),
      .buf_wd  (wr_data),
      .load    (load),
      .tick    (tick),
      .blk     (blk),
      .cnt     (cnt_q),
      .buf_val (buf_val[g]),
      .act_val (act_val[g]),
      .hit     (hit[g]),
      .pin     (cmp_out[g])
    );
  end

  // next-state logic for control, mask, flags and match suppression
  always_comb begin
    cs_d     = cs_q;
    topsel_d = topsel_q;
    mask_d   = mask_q;
    if (wr_en && wr_addr == RA_CTRL) begin
      cs_d     = wr_data[CS_W-1:0];
      topsel_d = wr_data[CS_W];
    end
    if (wr_en && wr_addr == RA_MASK) mask_d = wr_data[FLG_W-1:0];

    set_v   = {hit, ovf};
    clr_v   = (wr_en && wr_addr == RA_FLAG) ? wr_data[FLG_W-1:0] : '0;
    flags_d = (flags_q & ~clr_v) | set_v;

    if (cnt_wr)    supp_d = 1'b1;
    else if (tick) supp_d = 1'b0;
    else           supp_d = supp_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cs_q     <= '0;
      topsel_q <= 1'b0;
      mask_q   <= '0;
      flags_q  <= '0;
      supp_q   <= 1'b0;
    end else begin
      cs_q     <= cs_d;
      topsel_q <= topsel_d;
      mask_q   <= mask_d;
      flags_q  <= flags_d;
      supp_q   <= supp_d;
    end
  end

  assign irq = |(flags_q & mask_q);

  always_comb begin
    rd_data = '0;
    if (rd_addr == RA_CNT)  rd_data = cnt_q;
    if (rd_addr == RA_MASK) rd_data = WIDTH'(mask_q);
    if (rd_addr == RA_FLAG) rd_data = WIDTH'(flags_q);
    if (rd_addr == RA_CTRL) rd_data = WIDTH'({topsel_q, cs_q});
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == ADDR_W'(int'(RA_CMP0) + i)) rd_data = buf_val[i];
    end
  end

endmodule

// File: rtl/tmr8_dual_cmp_chk.sv
module tmr8_dual_cmp_chk
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cnt_wr,
  input logic [W-1:0]     wr_data,
  input logic [W-1:0]     cnt,
  input logic [W-1:0]     top,
  input logic [CS_W-1:0]  cs,
  input logic [FLG_W-1:0] flags,
  input logic [NCH-1:0]   pins
);

  a_r3_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (cs == '0 && !cnt_wr) |=> $stable(cnt));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && cnt != top) |=> (cnt == W'($past(cnt) + 1'b1)));

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && cnt == top) |=> (cnt == '0));

  a_r5_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && cnt == {W{1'b1}}) |=> flags[0]);

  a_r6_pins_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pins));

  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(wr_data)));

  a_r10_no_match: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $past(cnt_wr)) |=> $stable(pins));

endmodule

bind tmr8_dual_cmp tmr8_dual_cmp_chk #(.W(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .tick    (tick),
  .cnt_wr  (cnt_wr),
  .wr_data (wr_data),
  .cnt     (cnt_q),
  .top     (top_val),
  .cs      (cs_q),
  .flags   (flags_q),
  .pins    (cmp_out)
);

// File: tb/tmr8_dual_cmp_tb.sv
`timescale 1ns/1ps
module tmr8_dual_cmp_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [2:0] rd_addr;
  logic [7:0] rd_data;
  logic       irq;
  logic [1:0] cmp_out;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  tmr8_dual_cmp u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .irq     (irq),
    .cmp_out (cmp_out)
  );

  // row: we, wr_addr, wr_data, rd_addr, expected rd_data, expected irq, expected {pin1,pin0}
  localparam int NROW = 41;
  localparam logic [25:0] VEC [NROW] = '{
    {1'b1, 3'd1, 8'h05, 3'd1, 8'h05, 1'b0, 2'b00}, // R7 R11 buffer readback
    {1'b1, 3'd2, 8'h03, 3'd0, 8'h00, 1'b0, 2'b00},
    {1'b1, 3'd3, 8'h07, 3'd3, 8'h07, 1'b0, 2'b00}, // R11 mask
    {1'b1, 3'd0, 8'h01, 3'd0, 8'h01, 1'b0, 2'b00}, // R10 counter load
    {1'b1, 3'd5, 8'h01, 3'd0, 8'h01, 1'b0, 2'b00}, // R3 stopped, no step
    {1'b0, 3'd0, 8'h00, 3'd0, 8'h02, 1'b0, 2'b00}, // R3 step
    {1'b0, 3'd0, 8'h00, 3'd0, 8'h03, 1'b0, 2'b00},
    {1'b0, 3'd0, 8'h00, 3'd4, 8'h04, 1'b1, 2'b10}, // R6 ch1 match, R9
    {1'b1, 3'd4, 8'h04, 3'd4, 8'h00, 1'b0, 2'b10}, // R8 clear
    {1'b0, 3'd0, 8'h00, 3'd4, 8'h02, 1'b1, 2'b11}, // R6 ch0 match
    {1'b1, 3'd0, 8'hFE, 3'd0, 8'hFE, 1'b1, 2'b11},
    {1'b1, 3'd4, 8'h02, 3'd0, 8'hFF, 1'b0, 2'b11},
    {1'b0, 3'd0, 8'h00, 3'd4, 8'h01, 1'b1, 2'b11}, // R5 overflow, R4 wrap at 0xFF
    {1'b1, 3'd0, 8'hFF, 3'd0, 8'hFF, 1'b1, 2'b11},
    {1'b1, 3'd4, 8'h01, 3'd4, 8'h01, 1'b1, 2'b11}, // R8 set beats clear
    {1'b1, 3'd4, 8'h07, 3'd4, 8'h00, 1'b0, 2'b11},
    {1'b1, 3'd5, 8'h09, 3'd0, 8'h02, 1'b0, 2'b11}, // R4 select TOP = ch0
    {1'b1, 3'd1, 8'h03, 3'd0, 8'h03, 1'b0, 2'b11}, // R7 write buffer mid-period
    {1'b0, 3'd0, 8'h00, 3'd0, 8'h04, 1'b1, 2'b01}, // R7 old active 5 still TOP
    {1'b0, 3'd0, 8'h00, 3'd0, 8'h05, 1'b1, 2'b01},
    {1'b0, 3'd0, 8'h00, 3'd0, 8'h00, 1'b1, 2'b00}, // R4 wrap at ch0 value
    {1'b0, 3'd0, 8'h00, 3'd4, 8'h06, 1'b1, 2'b00},
    {1'b0, 3'd0, 8'h00, 3'd0, 8'h02, 1'b1, 2'b00},
    {1'b0, 3'd0, 8'h00, 3'd0, 8'h03, 1'b1, 2'b00},
    {1'b0, 3'd0, 8'h00, 3'd0, 8'h00, 1'b1, 2'b11}, // R7 new TOP 3, both match
    {1'b1, 3'd5, 8'h08, 3'd0, 8'h01, 1'b1, 2'b11},
    {1'b0, 3'd0, 8'h00, 3'd0, 8'h01, 1'b1, 2'b11}, // R3 frozen
    {1'b0, 3'd0, 8'h00, 3'd5, 8'h08, 1'b1, 2'b11}, // R11 control readback
    {1'b1, 3'd1, 8'h07, 3'd1, 8'h07, 1'b1, 2'b11}, // R7 stopped: immediate load
    {1'b0, 3'd0, 8'h00, 3'd0, 8'h01, 1'b1, 2'b11},
    {1'b1, 3'd0, 8'h06, 3'd0, 8'h06, 1'b1, 2'b11},
    {1'b1, 3'd5, 8'h09, 3'd0, 8'h06, 1'b1, 2'b11},
    {1'b0, 3'd0, 8'h00, 3'd0, 8'h07, 1'b1, 2'b11},
    {1'b0, 3'd0, 8'h00, 3'd0, 8'h00, 1'b1, 2'b10}, // R7 TOP already 7
    {1'b1, 3'd4, 8'h07, 3'd4, 8'h00, 1'b0, 2'b10},
    {1'b1, 3'd0, 8'h03, 3'd0, 8'h03, 1'b0, 2'b10}, // R10 load equal to ch1
    {1'b0, 3'd0, 8'h00, 3'd4, 8'h00, 1'b0, 2'b10}, // R10 next tick no match
    {1'b0, 3'd0, 8'h00, 3'd0, 8'h05, 1'b0, 2'b10},
    {1'b1, 3'd3, 8'h00, 3'd0, 8'h06, 1'b0, 2'b10},
    {1'b0, 3'd0, 8'h00, 3'd0, 8'h07, 1'b0, 2'b10},
    {1'b0, 3'd0, 8'h00, 3'd4, 8'h02, 1'b0, 2'b11}  // R9 flag set, mask 0: irq low
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cyc(input logic we, input logic [2:0] a, input logic [7:0] d, input logic [2:0] ra);
    wr_en   = we;
    wr_addr = a;
    wr_data = d;
    rd_addr = ra;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int div_of(input int cs);
    case (cs)
      1: return 1;
      2: return 8;
      3: return 32;
      4: return 64;
      5: return 128;
      6: return 256;
      default: return 1024;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state at every address
    for (int a = 0; a < 6; a++) begin
      rd_addr = 3'(a);
      #0.5;
      check($sformatf("R1 addr %0d", a), {8'h00, rd_data}, 16'h0000);
    end
    check("R1 irq and pins", {13'd0, irq, cmp_out}, 16'h0000);
    @(negedge clk);

    // table walk: R3 R4 R5 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < NROW; i++) begin
      logic [25:0] v;
      v = VEC[i];
      cyc(v[25], v[24:22], v[21:14], v[13:11]);
      check($sformatf("R11 row %0d", i + 1),
            {5'd0, rd_data, irq, cmp_out}, {5'd0, v[10:0]});
    end

    // R2 tick rates: exactly k ticks in a window of k*div clocks
    for (int cs = 1; cs < 8; cs++) begin
      int k;
      k = (cs == 1) ? 10 : 4;
      cyc(1'b1, 3'd5, 8'h00, 3'd0);
      cyc(1'b1, 3'd0, 8'h00, 3'd0);
      cyc(1'b1, 3'd5, 8'(cs), 3'd0);
      repeat (k * div_of(cs)) cyc(1'b0, 3'd0, 8'h00, 3'd0);
      check($sformatf("R2 select %0d", cs), {8'h00, rd_data}, 16'(k));
    end

    // R3 stopping freezes the count
    begin
      logic [7:0] held;
      cyc(1'b1, 3'd5, 8'h01, 3'd0);
      repeat (3) cyc(1'b0, 3'd0, 8'h00, 3'd0);
      cyc(1'b1, 3'd5, 8'h00, 3'd0);
      held = rd_data;
      repeat (20) cyc(1'b0, 3'd0, 8'h00, 3'd0);
      check("R3 freeze", {8'h00, rd_data}, {8'h00, held});
    end

    // R1 reset in the middle of operation
    cyc(1'b1, 3'd5, 8'h01, 3'd0);
    cyc(1'b1, 3'd3, 8'h07, 3'd0);
    repeat (5) cyc(1'b0, 3'd0, 8'h00, 3'd0);
    rst_n = 1'b0;
    #0.5;
    check("R1 mid-run counter", {8'h00, rd_data}, 16'h0000);
    rd_addr = 3'd5;
    #0.5;
    check("R1 mid-run control", {8'h00, rd_data}, 16'h0000);
    check("R1 mid-run irq and pins", {13'd0, irq, cmp_out}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule